// File: doc/BRIEF.md
# Interrupt Destination Matcher

This block sits beside one local interrupt controller and decides whether
that controller is a target of an inter-processor interrupt seen on the
shared message path. Each request carries an 8-bit destination, a physical
or logical addressing flag, a 2-bit shorthand and a 3-bit delivery mode.
The controller supplies its own physical ID, its logical ID and the upper
nibble of its destination format register, which picks flat or cluster
logical addressing. A flag also tells the block whether this controller is
the one sending the interrupt.

A request is presented with `req_vld` high for one clock. The block
registers its verdict and shows it for exactly the next cycle: `res_vld`
marks the result, `accept` says the controller is a target, and `cfg_err`
flags an illegal mix of cluster addressing with lowest-priority delivery.
Back-to-back requests give back-to-back results. A two-state machine
carries the result: `ST_IDLE` (nothing to show) moves to `ST_SHOW` on a
request; `ST_SHOW` stays in `ST_SHOW` while requests keep arriving and
returns to `ST_IDLE` on a cycle without one.

Top module: `ipi_dest_match`

## Requirements
- R1: While and after reset, before any request, `res_vld`, `accept` and `cfg_err` are 0.
- R2: A request sampled at a rising edge with `req_vld`=1 makes `res_vld`=1 for exactly the following cycle; whenever `res_vld`=0, `accept` and `cfg_err` are 0.
- R3: With shorthand 0 (none) and `dst_logical`=0 (physical), `accept`=1 exactly when `dest` equals `own_id`, except as given by R4.
- R4: With shorthand 0 and physical addressing, `dest`=0xFF (all ones) is a broadcast and gives `accept`=1 for any `own_id`.
- R5: With shorthand 0, `dst_logical`=1 and `fmt_hi`=4'hF (flat), `accept`=1 exactly when `dest & log_id` is nonzero.
- R6: With shorthand 0, `dst_logical`=1 and `fmt_hi` any value other than 4'hF (cluster), `accept`=1 exactly when `dest[3:0]` equals `log_id[3:0]` and `dest[7:4] & log_id[7:4]` is nonzero.
- R7: With shorthand 0, logical cluster addressing and `dlv_mode`=3'b001 (lowest priority), `cfg_err`=1 and `accept`=0; in every other case `cfg_err`=0.
- R8: Shorthand 1 (self) gives `accept`=1 exactly when `is_sender`=1.
- R9: Shorthand 2 (all including self) gives `accept`=1 for every controller.
- R10: Shorthand 3 (all excluding self) gives `accept`=1 exactly when `is_sender`=0.
- R11: With a nonzero shorthand, `dest`, `dst_logical`, `fmt_hi`, `log_id` and `dlv_mode` have no effect on `accept` or `cfg_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | A request is present this cycle |
| dest | input | 8 | Destination field of the request |
| dst_logical | input | 1 | 0 = physical addressing, 1 = logical addressing |
| shorthand | input | 2 | 0 none, 1 self, 2 all including self, 3 all excluding self |
| dlv_mode | input | 3 | Delivery mode; 3'b001 is lowest priority |
| is_sender | input | 1 | This controller issued the request |
| own_id | input | 8 | Physical ID of this controller |
| log_id | input | 8 | Logical ID of this controller |
| fmt_hi | input | 4 | Upper nibble of the destination format register; 4'hF flat, else cluster |
| res_vld | output | 1 | Verdict valid this cycle |
| accept | output | 1 | This controller is a target |
| cfg_err | output | 1 | Cluster addressing used with lowest-priority delivery |

## Verification
The assertions take the request fields as stable and meaningful only in the
cycle `req_vld` is high, and they compare the verdict a cycle later against
the fields sampled with `$past`, so they assume no field is treated as
carrying over from one request to the next. The stimulus drives every field
afresh on each request, changes inputs only on the falling edge, and keeps
`own_id`, `log_id` and `fmt_hi` fixed across any request whose result is
still pending, so each verdict depends only on the request that caused it.

// File: rtl/idm_pkg.sv
package idm_pkg;

    typedef enum logic [1:0] {
        SH_NONE    = 2'd0,
        SH_SELF    = 2'd1,
        SH_ALL_INC = 2'd2,
        SH_ALL_EXC = 2'd3
    } shorthand_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } state_e;

    typedef struct packed {
        logic acc;
        logic err;
    } verdict_t;

    localparam logic [2:0] DLV_LOWEST = 3'b001;

endpackage

// File: rtl/idm_phys_match.sv
module idm_phys_match #(
    parameter int ID_W = 8
) (
    input  logic [ID_W-1:0] dest,
    input  logic [ID_W-1:0] own_id,
    output logic            hit
);
    localparam logic [ID_W-1:0] BCAST = {ID_W{1'b1}};

    logic is_bcast;
    logic is_equal;

    always_comb begin
        is_bcast = (dest == BCAST);
        is_equal = (dest == own_id);
        hit      = is_bcast | is_equal;
    end
endmodule

// File: rtl/idm_logic_match.sv
module idm_logic_match #(
    parameter int ID_W  = 8,
    parameter int FMT_W = 4
) (
    input  logic [ID_W-1:0]  dest,
    input  logic [ID_W-1:0]  log_id,
    input  logic [FMT_W-1:0] fmt_hi,
    output logic             hit,
    output logic             cluster
);
    localparam int NIB = ID_W / 2;

    logic             flat_hit;
    logic             grp_same;
    logic [NIB-1:0]   member_and;
    logic             clu_hit;

    always_comb begin
        cluster    = ~(&fmt_hi);
        flat_hit   = |(dest & log_id);
        grp_same   = (dest[NIB-1:0] == log_id[NIB-1:0]);
        member_and = dest[ID_W-1:NIB] & log_id[ID_W-1:NIB];
        clu_hit    = grp_same & (|member_and);
        hit        = cluster ? clu_hit : flat_hit;
    end
endmodule

// File: rtl/idm_decide.sv
module idm_decide
    import idm_pkg::*;
(
    input  shorthand_e sh,
    input  logic       dst_logical,
    input  logic [2:0] dlv_mode,
    input  logic       is_sender,
    input  logic       phys_hit,
    input  logic       logic_hit,
    input  logic       cluster,
    output verdict_t   vd
);
    always_comb begin
        vd = '0;
        unique case (sh)
            SH_NONE: begin
                if (!dst_logical) begin
                    vd.acc = phys_hit;
                end else if (cluster && (dlv_mode == DLV_LOWEST)) begin
                    vd.err = 1'b1;
                end else begin
                    vd.acc = logic_hit;
                end
            end
            SH_SELF:    vd.acc = is_sender;
            SH_ALL_INC: vd.acc = 1'b1;
            SH_ALL_EXC: vd.acc = ~is_sender;
        endcase
    end
endmodule

// File: rtl/ipi_dest_match.sv
module ipi_dest_match
    import idm_pkg::*;
#(
    parameter int ID_W  = 8,
    parameter int FMT_W = 4,
    parameter int SH_W  = 2,
    parameter int DM_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_vld,
    input  logic [ID_W-1:0]  dest,
    input  logic             dst_logical,
    input  logic [SH_W-1:0]  shorthand,
    input  logic [DM_W-1:0]  dlv_mode,
    input  logic             is_sender,
    input  logic [ID_W-1:0]  own_id,
    input  logic [ID_W-1:0]  log_id,
    input  logic [FMT_W-1:0] fmt_hi,
    output logic             res_vld,
    output logic             accept,
    output logic             cfg_err
);
    state_e   state_q, state_d;
    verdict_t vd_now, vd_q;
    logic     phys_hit, logic_hit, cluster;

    idm_phys_match #(.ID_W(ID_W)) u_phys (
        .dest   (dest),
        .own_id (own_id),
        .hit    (phys_hit)
    );

    idm_logic_match #(.ID_W(ID_W), .FMT_W(FMT_W)) u_logic (
        .dest    (dest),
        .log_id  (log_id),
        .fmt_hi  (fmt_hi),
        .hit     (logic_hit),
        .cluster (cluster)
    );

    idm_decide u_decide (
        .sh          (shorthand_e'(shorthand)),
        .dst_logical (dst_logical),
        .dlv_mode    (dlv_mode),
        .is_sender   (is_sender),
        .phys_hit    (phys_hit),
        .logic_hit   (logic_hit),
        .cluster     (cluster),
        .vd          (vd_now)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_vld)  state_d = ST_SHOW;
            ST_SHOW: if (!req_vld) state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // verdict capture
    always_ff @(posedge clk) begin
        if (!rst_n)       vd_q <= '0;
        else if (req_vld) vd_q <= vd_now;
    end

    // outputs
    always_comb begin
        res_vld = 1'b0;
        accept  = 1'b0;
        cfg_err = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SHOW: begin
                res_vld = 1'b1;
                accept  = vd_q.acc;
                cfg_err = vd_q.err;
            end
        endcase
    end
endmodule

// File: rtl/idm_chk.sv
module idm_chk #(
    parameter int ID_W  = 8,
    parameter int FMT_W = 4,
    parameter int SH_W  = 2,
    parameter int DM_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_vld,
    input logic [ID_W-1:0]  dest,
    input logic             dst_logical,
    input logic [SH_W-1:0]  shorthand,
    input logic [DM_W-1:0]  dlv_mode,
    input logic             is_sender,
    input logic [FMT_W-1:0] fmt_hi,
    input logic             res_vld,
    input logic             accept,
    input logic             cfg_err
);
    // R2
    res_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> res_vld);

    // R2
    res_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !res_vld);

    // R2
    quiet_when_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_vld |-> (!accept && !cfg_err));

    // R4
    bcast_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && shorthand == 2'd0 && !dst_logical && dest == {ID_W{1'b1}})
        |=> accept);

    // R7
    err_blocks_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !accept);

    // R7
    err_needs_cluster_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !(shorthand == 2'd0 && dst_logical && !(&fmt_hi)
                      && dlv_mode == 3'b001)) |=> !cfg_err);

    // R8
    self_only_sender_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && shorthand == 2'd1) |=> (accept == $past(is_sender)));

    // R9
    all_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && shorthand == 2'd2) |=> accept);

    // R10
    all_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && shorthand == 2'd3) |=> (accept == !$past(is_sender)));
endmodule

bind ipi_dest_match idm_chk #(
    .ID_W(ID_W), .FMT_W(FMT_W), .SH_W(SH_W), .DM_W(DM_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_vld     (req_vld),
    .dest        (dest),
    .dst_logical (dst_logical),
    .shorthand   (shorthand),
    .dlv_mode    (dlv_mode),
    .is_sender   (is_sender),
    .fmt_hi      (fmt_hi),
    .res_vld     (res_vld),
    .accept      (accept),
    .cfg_err     (cfg_err)
);

// File: tb/sim_ipi_dest_match.sv
module sim_ipi_dest_match;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_vld = 1'b0;
    logic [7:0] dest = '0;
    logic       dst_logical = 1'b0;
    logic [1:0] shorthand = '0;
    logic [2:0] dlv_mode = '0;
    logic       is_sender = 1'b0;
    logic [7:0] own_id = 8'h23;
    logic [7:0] log_id = 8'h24;
    logic [3:0] fmt_hi = 4'hF;
    logic       res_vld, accept, cfg_err;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    typedef struct {
        logic  acc;
        logic  err;
        string tag;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    ipi_dest_match u0 (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .dest(dest),
        .dst_logical(dst_logical), .shorthand(shorthand), .dlv_mode(dlv_mode),
        .is_sender(is_sender), .own_id(own_id), .log_id(log_id),
        .fmt_hi(fmt_hi), .res_vld(res_vld), .accept(accept), .cfg_err(cfg_err)
    );

    function automatic exp_t model(input logic [7:0] d, input logic lg,
                                   input logic [1:0] sh, input logic [2:0] dm,
                                   input logic snd, input logic [7:0] oid,
                                   input logic [7:0] lid, input logic [3:0] fm);
        exp_t e;
        e.acc = 0; e.err = 0; e.tag = "";
        if (sh == 2'd1)      e.acc = snd;
        else if (sh == 2'd2) e.acc = 1;
        else if (sh == 2'd3) e.acc = !snd;
        else if (!lg)        e.acc = (d == 8'hFF) || (d == oid);
        else if (fm == 4'hF) e.acc = ((d & lid) != 0);
        else if (dm == 3'b001) e.err = 1;
        else e.acc = (d[3:0] == lid[3:0]) && ((d[7:4] & lid[7:4]) != 0);
        return e;
    endfunction

    task automatic send(input logic [7:0] d, input logic lg, input logic [1:0] sh,
                        input logic [2:0] dm, input logic snd, input logic [7:0] lid,
                        input logic [3:0] fm, input string tag);
        exp_t e;
        @(negedge clk);
        dest = d; dst_logical = lg; shorthand = sh; dlv_mode = dm;
        is_sender = snd; log_id = lid; fmt_hi = fm; req_vld = 1'b1;
        e = model(d, lg, sh, dm, snd, own_id, lid, fm);
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_vld = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input string msg);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    // monitor: pops one expected item per valid result
    always @(posedge clk) begin
        #2;
        if (rst_n && res_vld) begin
            if (q.size() == 0) begin
                check(0, "R2", "result with no request pending");
            end else begin
                exp_t e;
                e = q.pop_front();
                check(accept === e.acc && cfg_err === e.err, e.tag,
                      $sformatf("accept/cfg_err actual %b/%b expected %b/%b",
                                accept, cfg_err, e.acc, e.err));
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(res_vld === 0 && accept === 0 && cfg_err === 0, "R1",
              $sformatf("in reset actual %b%b%b expected 000", res_vld, accept, cfg_err));
        rst_n = 1'b1;
        @(negedge clk);
        check(res_vld === 0 && accept === 0 && cfg_err === 0, "R1",
              $sformatf("after reset actual %b%b%b expected 000", res_vld, accept, cfg_err));

        // R3 physical
        send(8'h23, 0, 0, 3'b000, 0, 8'h24, 4'hF, "R3 equal id");
        send(8'h22, 0, 0, 3'b000, 0, 8'h24, 4'hF, "R3 other id");
        // R4 broadcast
        send(8'hFF, 0, 0, 3'b000, 0, 8'h24, 4'hF, "R4 broadcast");
        // R5 flat logical
        send(8'h04, 1, 0, 3'b000, 0, 8'h24, 4'hF, "R5 flat hit");
        send(8'h81, 1, 0, 3'b000, 0, 8'h24, 4'hF, "R5 flat miss");
        send(8'h81, 1, 0, 3'b001, 0, 8'h24, 4'hF, "R7 flat lowest no error");
        // R6 cluster logical
        send(8'h13, 1, 0, 3'b000, 0, 8'h53, 4'h0, "R6 cluster hit");
        send(8'h22, 1, 0, 3'b000, 0, 8'h53, 4'h0, "R6 cluster group miss");
        send(8'hA3, 1, 0, 3'b000, 0, 8'h53, 4'h0, "R6 cluster member miss");
        send(8'h13, 1, 0, 3'b000, 0, 8'h53, 4'h7, "R6 partial fmt is cluster");
        // R7 error
        send(8'h13, 1, 0, 3'b001, 0, 8'h53, 4'h0, "R7 cluster lowest error");
        send(8'h23, 0, 0, 3'b001, 0, 8'h53, 4'h0, "R7 physical lowest no error");
        // R8..R10 shorthands
        send(8'h00, 0, 1, 3'b000, 1, 8'h24, 4'hF, "R8 self sender");
        send(8'h23, 0, 1, 3'b000, 0, 8'h24, 4'hF, "R8 self other");
        send(8'h00, 1, 2, 3'b000, 0, 8'h00, 4'hF, "R9 all incl other");
        send(8'h00, 0, 2, 3'b000, 1, 8'h24, 4'hF, "R9 all incl sender");
        send(8'h23, 0, 3, 3'b000, 1, 8'h24, 4'hF, "R10 all excl sender");
        send(8'h00, 0, 3, 3'b000, 0, 8'h24, 4'hF, "R10 all excl other");
        // R11 fields ignored under shorthand
        send(8'h13, 1, 1, 3'b001, 0, 8'h53, 4'h0, "R11 self ignores cluster lowest");
        send(8'h13, 1, 3, 3'b001, 0, 8'h53, 4'h0, "R11 excl ignores cluster lowest");
        // R2 gap: result must vanish
        idle(0);
        @(negedge clk);
        check(res_vld === 0 && accept === 0 && cfg_err === 0, "R2",
              $sformatf("idle actual %b%b%b expected 000", res_vld, accept, cfg_err));
        check(q.size() == 0, "R2",
              $sformatf("pending actual %0d expected 0", q.size()));
        send(8'h23, 0, 0, 3'b000, 0, 8'h24, 4'hF, "R2 single after gap");
        idle(2);
        check(q.size() == 0, "R2",
              $sformatf("pending actual %0d expected 0", q.size()));
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule